// File: doc/BRIEF.md
# UDP Register Access and Stream Responder

This block sits behind a UDP receive path that has already matched the board's address (192.168.7.100, port 0x2017) and the host's address (192.168.7.200, port 0x2018). It takes the received UDP payload as a byte stream with start, end and valid markers. It decodes a one-byte opcode protocol that reads and writes a small register file. It produces transmit payloads with a length, which an external framer wraps into UDP, IP and Ethernet headers.

A read request makes the block send a short reply packet that carries the register value. A write request changes a register and gets no reply. Three registers control a streaming timer. While streaming is enabled, each expiry of the timer sends a long packet: a 32-bit sequence number followed by a fixed 256-byte data block. Writing zero to the enable register stops the stream.

Top module: `udp_regresp`

## Requirements
- R1: After reset, `tx_valid` is low. Scratch registers read 0x00. The period registers read the reset period (default 1000: high byte 0x03, low byte 0xE8). The enable register at 0x82 reads 0x00.
- R2: A payload whose first byte is 0x01 and whose second byte is an address is a read request. It yields one reply packet of 3 bytes with `tx_len` = 3: 0x01, the address, then the register value. `tx_sop` marks the first byte and `tx_eop` marks the last byte.
- R3: A payload of the form 0x02, address, data writes the data into the register. No packet is sent in response.
- R4: Bytes that follow the bytes an opcode needs have no effect on the request.
- R5: A payload is dropped with no register change and no reply in either of two cases: its first byte is neither 0x01 nor 0x02, or it is shorter than its opcode needs (2 bytes for a read, 3 for a write).
- R6: Register map: 0x00 to 0x0F are read/write scratch bytes. 0x80 is the timer period high byte and 0x81 the low byte. 0x82 is the stream enable, active when nonzero. Any other address reads 0x00 and ignores writes.
- R7: While enabled, the timer sends a stream packet every time it has counted period+1 clock cycles. A stream packet has `tx_len` = 260: 4 sequence bytes, most significant first, then bytes 0x00, 0x01, ..., 0xFF.
- R8: The sequence number is 0 for the first stream packet after reset and increases by one after each stream packet.
- R9: Once 0x00 is written to 0x82, no new stream packet starts. A packet already in progress completes.
- R10: When a read reply and a stream packet are both waiting at a packet boundary, the reply is sent first.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_len`, `tx_sop` and `tx_eop` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| rx_valid | input | 1 | Received payload byte present |
| rx_sop | input | 1 | First byte of a payload |
| rx_eop | input | 1 | Last byte of a payload |
| rx_data | input | 8 | Received payload byte |
| tx_ready | input | 1 | Framer accepts the current transmit byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_sop | output | 1 | First byte of a transmit payload |
| tx_eop | output | 1 | Last byte of a transmit payload |
| tx_data | output | 8 | Transmit payload byte |
| tx_len | output | 16 | Length in bytes of the payload being sent (3 or 260) |

## Verification
The assertions assume two things about the inputs. First, `rx_sop` and `rx_eop` are only raised together with `rx_valid`. Second, the host waits for a read reply before it sends the next read, so a waiting reply is never overwritten. The stimulus follows both rules: it sends each payload as one contiguous burst with correct markers, and every read task waits for its reply before it returns. The one read issued during streaming is sent alone and its reply is awaited. Backpressure is applied only by holding `tx_ready` low, which the framer is allowed to do at any time.

// File: rtl/udp_regresp_pkg.sv
package udp_regresp_pkg;
  localparam logic [7:0] OP_RD       = 8'h01;
  localparam logic [7:0] OP_WR       = 8'h02;
  localparam logic [7:0] ADDR_PER_HI = 8'h80;
  localparam logic [7:0] ADDR_PER_LO = 8'h81;
  localparam logic [7:0] ADDR_EN     = 8'h82;
  localparam int         REPLY_LEN   = 3;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_REPLY  = 2'd1,
    TX_STREAM = 2'd2
  } tx_state_t;
endpackage

// File: rtl/udp_rx_parse.sv
module udp_rx_parse
  import udp_regresp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_sop,
  input  logic       rx_eop,
  input  logic [7:0] rx_data,
  output logic       rd_req,
  output logic       wr_req,
  output logic [7:0] req_addr,
  output logic [7:0] wr_data
);
  logic [1:0] idx_q, idx_d, pos;
  logic [7:0] op_q, op_d, addr_q, addr_d, dat_q, dat_d;
  logic [7:0] b_op;
  logic       done;

  // Byte position within the payload; saturates at 3 (enough for any opcode)
  always_comb begin
    pos      = rx_sop ? 2'd0 : idx_q;
    b_op     = (pos == 2'd0) ? rx_data : op_q;
    req_addr = (pos == 2'd1) ? rx_data : addr_q;
    wr_data  = (pos == 2'd2) ? rx_data : dat_q;
    done     = rx_valid && rx_eop;
    rd_req   = done && (b_op == OP_RD) && (pos >= 2'd1);
    wr_req   = done && (b_op == OP_WR) && (pos >= 2'd2);
  end

  always_comb begin
    idx_d  = idx_q;
    op_d   = op_q;
    addr_d = addr_q;
    dat_d  = dat_q;
    if (rx_valid) begin
      if (pos == 2'd0) op_d   = rx_data;
      if (pos == 2'd1) addr_d = rx_data;
      if (pos == 2'd2) dat_d  = rx_data;
      if (done)                idx_d = 2'd0;
      else if (pos != 2'd3)    idx_d = pos + 2'd1;
      else                     idx_d = pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= 2'd0;
      op_q   <= 8'h00;
      addr_q <= 8'h00;
      dat_q  <= 8'h00;
    end else begin
      idx_q  <= idx_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      dat_q  <= dat_d;
    end
  end
endmodule

// File: rtl/udp_regfile.sv
module udp_regfile
  import udp_regresp_pkg::*;
#(
  parameter int          NUM_SCRATCH = 16,
  parameter logic [15:0] PERIOD_RST  = 16'd1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic [15:0] period,
  output logic        stream_en
);
  localparam int         SCR_AW  = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;
  localparam logic [7:0] SCR_LIM = 8'(NUM_SCRATCH);

  logic [8*NUM_SCRATCH-1:0] scr_flat;
  logic [7:0] per_hi_q, per_lo_q, en_q;

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scr
    logic [7:0] q;
    logic       hit;
    assign hit = wr_en && (addr == 8'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 8'h00;
      else if (hit) q <= wr_data;
    end
    assign scr_flat[8*i +: 8] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_hi_q <= PERIOD_RST[15:8];
      per_lo_q <= PERIOD_RST[7:0];
      en_q     <= 8'h00;
    end else if (wr_en) begin
      if (addr == ADDR_PER_HI) per_hi_q <= wr_data;
      if (addr == ADDR_PER_LO) per_lo_q <= wr_data;
      if (addr == ADDR_EN)     en_q     <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr < SCR_LIM)            rd_data = scr_flat[8*addr[SCR_AW-1:0] +: 8];
    else if (addr == ADDR_PER_HI)  rd_data = per_hi_q;
    else if (addr == ADDR_PER_LO)  rd_data = per_lo_q;
    else if (addr == ADDR_EN)      rd_data = en_q;
  end

  assign period    = {per_hi_q, per_lo_q};
  assign stream_en = (en_q != 8'h00);
endmodule

// File: rtl/udp_stream_timer.sv
module udp_stream_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [15:0] period,
  input  logic        ack,
  output logic        req
);
  logic [15:0] cnt_q, cnt_d;
  logic        pend_q, pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!enable) begin
      cnt_d  = 16'd0;
      pend_d = 1'b0;
    end else if (pend_q) begin
      if (ack) pend_d = 1'b0;
    end else if (cnt_q >= period) begin
      pend_d = 1'b1;
      cnt_d  = 16'd0;
    end else begin
      cnt_d = cnt_q + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 16'd0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // Gated with the live enable so a stop write wins over a pending expiry
  assign req = pend_q && enable;
endmodule

// File: rtl/udp_tx_mux.sv
module udp_tx_mux
  import udp_regresp_pkg::*;
#(
  parameter int BLOCK_LEN = 256,
  parameter int SEQ_W     = 32,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [7:0]       rd_addr,
  input  logic [7:0]       rd_val,
  input  logic             st_req,
  input  logic             tx_ready,
  output logic             st_ack,
  output logic             rd_pend,
  output logic             tx_valid,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic [7:0]       tx_data,
  output logic [LEN_W-1:0] tx_len
);
  localparam int SEQ_B  = SEQ_W / 8;
  localparam int ST_LEN = SEQ_B + BLOCK_LEN;
  localparam int CNT_W  = $clog2(ST_LEN + 1);

  tx_state_t        state_q, state_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d, plen;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic             rp_q, rp_d;
  logic [7:0]       ra_q, ra_d, rv_q, rv_d;
  logic             start_rd, last, fire;

  always_comb begin
    start_rd = (state_q == TX_IDLE) && rp_q;
    st_ack   = (state_q == TX_IDLE) && !rp_q && st_req;
    plen     = (state_q == TX_REPLY) ? CNT_W'(REPLY_LEN) : CNT_W'(ST_LEN);
    last     = (bcnt_q == plen - CNT_W'(1));
    tx_valid = (state_q != TX_IDLE);
    fire     = tx_valid && tx_ready;
    tx_sop   = tx_valid && (bcnt_q == '0);
    tx_eop   = tx_valid && last;
    tx_len   = tx_valid ? LEN_W'(plen) : '0;
    tx_data  = 8'h00;
    if (state_q == TX_REPLY) begin
      if (bcnt_q == CNT_W'(0))      tx_data = OP_RD;
      else if (bcnt_q == CNT_W'(1)) tx_data = ra_q;
      else                          tx_data = rv_q;
    end else if (state_q == TX_STREAM) begin
      if (bcnt_q < CNT_W'(SEQ_B)) begin
        for (int k = 0; k < SEQ_B; k++)
          if (bcnt_q == CNT_W'(k)) tx_data = seq_q[8*(SEQ_B-1-k) +: 8];
      end else begin
        tx_data = 8'(bcnt_q - CNT_W'(SEQ_B));
      end
    end
  end

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    seq_d   = seq_q;
    rp_d    = rp_q;
    ra_d    = ra_q;
    rv_d    = rv_q;
    if (start_rd) rp_d = 1'b0;
    if (rd_req && (!rp_q || start_rd)) begin
      rp_d = 1'b1;
      ra_d = rd_addr;
      rv_d = rd_val;
    end
    if (start_rd) begin
      state_d = TX_REPLY;
      bcnt_d  = '0;
    end else if (st_ack) begin
      state_d = TX_STREAM;
      bcnt_d  = '0;
    end else if (fire) begin
      if (last) begin
        state_d = TX_IDLE;
        bcnt_d  = '0;
        if (state_q == TX_STREAM) seq_d = seq_q + SEQ_W'(1);
      end else begin
        bcnt_d = bcnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      bcnt_q  <= '0;
      seq_q   <= '0;
      rp_q    <= 1'b0;
      ra_q    <= 8'h00;
      rv_q    <= 8'h00;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      seq_q   <= seq_d;
      rp_q    <= rp_d;
      ra_q    <= ra_d;
      rv_q    <= rv_d;
    end
  end

  assign rd_pend = rp_q;
endmodule

// File: rtl/udp_regresp.sv
module udp_regresp #(
  parameter int          NUM_SCRATCH = 16,
  parameter logic [15:0] PERIOD_RST  = 16'd1000,
  parameter int          BLOCK_LEN   = 256,
  parameter int          SEQ_W       = 32,
  parameter int          LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sop,
  input  logic             rx_eop,
  input  logic [7:0]       rx_data,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic [7:0]       tx_data,
  output logic [LEN_W-1:0] tx_len
);
  logic        rd_req, wr_req, stream_en, st_req, st_ack, rd_pend;
  logic [7:0]  req_addr, wr_data, rd_val;
  logic [15:0] period;

  udp_rx_parse u_parse (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
    .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr), .wr_data(wr_data)
  );

  udp_regfile #(.NUM_SCRATCH(NUM_SCRATCH), .PERIOD_RST(PERIOD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_req), .addr(req_addr), .wr_data(wr_data),
    .rd_data(rd_val), .period(period), .stream_en(stream_en)
  );

  udp_stream_timer u_timer (
    .clk(clk), .rst_n(rst_n),
    .enable(stream_en), .period(period), .ack(st_ack), .req(st_req)
  );

  udp_tx_mux #(.BLOCK_LEN(BLOCK_LEN), .SEQ_W(SEQ_W), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_addr(req_addr), .rd_val(rd_val),
    .st_req(st_req), .tx_ready(tx_ready),
    .st_ack(st_ack), .rd_pend(rd_pend),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_data(tx_data), .tx_len(tx_len)
  );
endmodule

// File: rtl/udp_regresp_chk.sv
module udp_regresp_chk #(
  parameter int ST_LEN = 260,
  parameter int LEN_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_sop,
  input logic             rx_eop,
  input logic             tx_ready,
  input logic             tx_valid,
  input logic             tx_sop,
  input logic             tx_eop,
  input logic [7:0]       tx_data,
  input logic [LEN_W-1:0] tx_len,
  input logic             stream_en,
  input logic             rd_pend
);
  // R2: input framing taken for granted
  p_rx_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sop || rx_eop) |-> rx_valid);

  p_tx_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sop || tx_eop) |-> tx_valid);

  p_reply_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_sop) && tx_len == LEN_W'(3)) |-> tx_data == 8'h01);

  p_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_len == LEN_W'(3) || tx_len == LEN_W'(ST_LEN)));

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_sop) && tx_len == LEN_W'(ST_LEN)) |-> $past(stream_en));

  p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_sop) && $past(rd_pend)) |-> tx_len == LEN_W'(3));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_len)
                                 && $stable(tx_sop) && $stable(tx_eop)));
endmodule

bind udp_regresp udp_regresp_chk #(.ST_LEN(SEQ_W/8 + BLOCK_LEN), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
  .tx_data(tx_data), .tx_len(tx_len),
  .stream_en(stream_en), .rd_pend(rd_pend)
);

// File: tb/sim_udp_regresp.sv
`timescale 1ns/1ps
module sim_udp_regresp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, tx_ready = 1'b1;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_valid, tx_sop, tx_eop;
  logic [7:0]  tx_data;
  logic [15:0] tx_len;

  always #4 clk = ~clk;

  udp_regresp u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_data(tx_data), .tx_len(tx_len)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Transmit monitor: samples on the falling edge
  logic [7:0] cur [0:299];
  logic [7:0] lastp [0:299];
  int cur_n = 0, last_n = 0, n_pkts = 0, n_str = 0, fmt_err = 0;

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if ((cur_n == 0) != tx_sop) fmt_err++;
      if (cur_n < 300) cur[cur_n] = tx_data;
      cur_n++;
      if (tx_eop) begin
        if (cur_n != int'(tx_len)) fmt_err++;
        for (int i = 0; i < 300; i++) lastp[i] = cur[i];
        last_n = cur_n;
        cur_n  = 0;
        n_pkts++;
        if (tx_len != 16'd3) n_str++;
      end
    end
  end

  task automatic send(input logic [7:0] b0, b1, b2, b3, b4, input int n);
    logic [7:0] b [5];
    b = '{b0, b1, b2, b3, b4};
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == n - 1); rx_data = b[i];
    end
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  task automatic wait_pkts(input int target);
    int t = 0;
    while (n_pkts < target && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send(8'h02, a, d, 8'h00, 8'h00, 3);
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    int n0 = n_pkts;
    send(8'h01, a, 8'h00, 8'h00, 8'h00, 2);
    wait_pkts(n0 + 1);
    chk(n_pkts == n0 + 1 && last_n == 3 && lastp[0] == 8'h01 && lastp[1] == a,
        {tag, " reply frame"}, last_n, 3);
    chk(lastp[2] == exp, tag, lastp[2], exp);
  endtask

  task automatic t_reset;
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
    rd_check(8'h03, 8'h00, "R1 scratch reset");
    rd_check(8'h80, 8'h03, "R1 period high reset");
    rd_check(8'h81, 8'hE8, "R1 period low reset");
    rd_check(8'h82, 8'h00, "R1 enable reset");
  endtask

  task automatic t_rw;
    int n0 = n_pkts;
    wr(8'h01, 8'h55);
    repeat (10) @(negedge clk);
    chk(n_pkts == n0, "R3 no reply to write", n_pkts, n0);
    rd_check(8'h01, 8'h55, "R2 R3 read back");
    chk(fmt_err == 0, "R2 sop/eop/len framing", fmt_err, 0);
  endtask

  task automatic t_extra;
    send(8'h02, 8'h05, 8'hA7, 8'hFF, 8'hFF, 5);
    rd_check(8'h05, 8'hA7, "R4 write with trailing bytes");
    send(8'h01, 8'h05, 8'h33, 8'h44, 8'h00, 4);
    wait_pkts(n_pkts + 1);
    chk(last_n == 3 && lastp[1] == 8'h05 && lastp[2] == 8'hA7, "R4 read with trailing bytes",
        lastp[2], 8'hA7);
  endtask

  task automatic t_drop;
    int n0;
    send(8'h03, 8'h05, 8'h11, 8'h00, 8'h00, 3);
    send(8'h02, 8'h05, 8'h00, 8'h00, 8'h00, 2);
    n0 = n_pkts;
    send(8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 1);
    repeat (10) @(negedge clk);
    chk(n_pkts == n0, "R5 short read gives no reply", n_pkts, n0);
    rd_check(8'h05, 8'hA7, "R5 dropped writes leave register");
  endtask

  task automatic t_map;
    wr(8'h40, 8'h99);
    rd_check(8'h40, 8'h00, "R6 unmapped address");
    wr(8'h0F, 8'h3C);
    rd_check(8'h0F, 8'h3C, "R6 top scratch");
    wr(8'h10, 8'h77);
    rd_check(8'h10, 8'h00, "R6 just past scratch");
  endtask

  task automatic t_stream;
    int s0, t, errs;
    wr(8'h80, 8'h00);
    wr(8'h81, 8'h14);
    rd_check(8'h81, 8'h14, "R6 period low write");
    s0 = n_str;
    wr(8'h82, 8'h01);
    t = 0;
    while (n_str < s0 + 1 && t < 3000) begin @(negedge clk); t++; end
    chk(last_n == 260, "R7 stream length", last_n, 260);
    chk({lastp[0], lastp[1], lastp[2], lastp[3]} == 32'd0, "R8 first sequence",
        {lastp[0], lastp[1], lastp[2], lastp[3]}, 0);
    errs = 0;
    for (int i = 0; i < 256; i++) if (lastp[4 + i] != 8'(i)) errs++;
    chk(errs == 0, "R7 data block bytes", errs, 0);
    t = 0;
    while (n_str < s0 + 2 && t < 3000) begin @(negedge clk); t++; end
    chk({lastp[0], lastp[1], lastp[2], lastp[3]} == 32'd1, "R8 second sequence",
        {lastp[0], lastp[1], lastp[2], lastp[3]}, 1);
  endtask

  task automatic t_prio;
    int n0, t = 0;
    while (!(tx_valid && tx_sop && tx_len == 16'd260) && t < 3000) begin @(negedge clk); t++; end
    n0 = n_pkts;
    send(8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 2);
    wait_pkts(n0 + 2);
    chk(last_n == 3 && lastp[2] == 8'h55, "R10 reply before next stream", last_n, 3);
  endtask

  task automatic t_stop;
    int s0;
    wr(8'h82, 8'h00);
    repeat (400) @(negedge clk);
    s0 = n_str;
    repeat (600) @(negedge clk);
    chk(n_str == s0, "R9 stream stopped", n_str, s0);
    rd_check(8'h82, 8'h00, "R9 enable reads zero");
  endtask

  task automatic t_bp;
    int n0 = n_pkts;
    @(posedge clk); #1; tx_ready = 1'b0;
    send(8'h01, 8'h05, 8'h00, 8'h00, 8'h00, 2);
    repeat (6) @(negedge clk);
    chk(tx_valid && tx_sop && tx_data == 8'h01 && tx_len == 16'd3, "R11 held first byte",
        tx_data, 8'h01);
    repeat (5) @(negedge clk);
    chk(tx_valid && tx_sop && tx_data == 8'h01, "R11 still held", tx_data, 8'h01);
    @(posedge clk); #1; tx_ready = 1'b1;
    wait_pkts(n0 + 1);
    chk(last_n == 3 && lastp[1] == 8'h05 && lastp[2] == 8'hA7, "R11 reply after release",
        lastp[2], 8'hA7);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset;
    t_rw;
    t_extra;
    t_drop;
    t_map;
    t_stream;
    t_prio;
    t_stop;
    t_bp;
    done = 1'b1;
    summary;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary;
      $finish;
    end
  end
endmodule